// File: doc/BRIEF.md
# Banked framebuffer window address mapper

This block sits between a host bus and video RAM. It turns byte accesses that land in the legacy graphics aperture (host addresses 0xA0000 to 0xBFFFF) into video RAM addresses. A 2-bit map mode selects one of four windows. Three of them are fixed. The fourth is a 64 KiB window that software can move anywhere in video RAM by writing a bank number. Accesses that fall outside the selected window never reach the RAM. A read there returns 0xFF and a write there is dropped.

The bank number is masked to the number of 64 KiB banks the RAM holds. It is kept internally as a signed offset, taken modulo 2^32, that is added to the host address. Two events put the window back on bank 0: reset, and a write of the extended-mode enable with the value 0. An accepted access drives the RAM strobes one cycle after the request. For a read, the data returns to the host two cycles after the request. A rejected read returns in that same cycle.

Top module: `wmap_top`

## Requirements
- R1: In map mode 0, host addresses 0xA0000 to 0xBFFFF are accepted and map to RAM address (host − 0xA0000). The bank number has no effect in this mode.
- R2: In map mode 1, host addresses 0xA0000 to 0xAFFFF are accepted and map to RAM address host + (bank << 16) − 0xA0000. The arithmetic is modulo 2^32, and the result is truncated to VRAM_AW bits. Addresses at or above 0xB0000 are rejected.
- R3: A bank write stores bank_num AND (2^(VRAM_AW−16) − 1). With VRAM_AW = 22 the mask is 0x3F, so bank 0x47 selects bank 7 and bank 0xC0 selects bank 0.
- R4: After reset, the mode-1 window maps bank 0. A mode_we pulse with ext_enable = 0 also restores bank 0, and it wins over a bank write in the same cycle. A mode_we pulse with ext_enable = 1 leaves the bank unchanged.
- R5: In map mode 2, host addresses 0xB0000 to 0xB7FFF are accepted and map to (host − 0xB0000).
- R6: In map mode 3, host addresses 0xB8000 to 0xBFFFF are accepted and map to (host − 0xB8000).
- R7: A host address outside the selected window is rejected. This includes addresses below 0xA0000 and addresses wider than 20 bits. A rejected access never raises vram_en or vram_we, and a rejected read returns host_rdata = 0xFF.
- R8: For an accepted access, vram_en, vram_we and vram_addr hold the result one cycle after the request. host_rvalid is high exactly two cycles after each read request, whether the read was accepted or rejected, and never for a write. After reset, vram_en, vram_we and host_rvalid are 0.
- R9: For an accepted read, host_rdata equals the vram_rdata value the RAM returns in the cycle after vram_en.
- R10: For an accepted write, vram_wdata carries host_wdata and vram_we is high together with vram_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | HOST_AW | Host byte address |
| host_rd | input | 1 | Read request strobe, one cycle |
| host_wr | input | 1 | Write request strobe, one cycle |
| host_wdata | input | 8 | Host write byte |
| map_mode | input | 2 | Window select, 0 to 3 |
| bank_we | input | 1 | Load a new bank number |
| bank_num | input | BANK_W | Bank number, in 64 KiB units |
| mode_we | input | 1 | Write of the extended-mode enable |
| ext_enable | input | 1 | Extended-mode enable value, sampled with mode_we |
| vram_addr | output | VRAM_AW | Video RAM byte address |
| vram_en | output | 1 | Video RAM access enable |
| vram_we | output | 1 | Video RAM write enable |
| vram_wdata | output | 8 | Video RAM write byte |
| vram_rdata | input | 8 | Video RAM read byte, one cycle after vram_en |
| host_rdata | output | 8 | Read data to the host |
| host_rvalid | output | 1 | host_rdata is valid |

## Verification
The assertions assume that the host never raises host_rd and host_wr in the same cycle. They also assume that all request and control strobes are held low while reset is asserted, because the latency and bank-offset properties look back across the release of reset. The stimulus issues one request per cycle at most, with only one strobe high. It changes the bank and the mode only between accesses, and it keeps every strobe at 0 during each reset pulse. The RAM model in the stimulus answers reads one cycle after vram_en, with a byte computed from the address. This lets each returned byte identify the address that produced it.

// File: rtl/wmap_pkg.sv
// Shared constants and window helpers for the banked window mapper.
// Assumes a 20-bit legacy aperture; all window bounds are byte addresses.
package wmap_pkg;

    // Window select values carried on map_mode.
    typedef enum logic [1:0] {
        MAP_WIDE   = 2'd0,
        MAP_BANKED = 2'd1,
        MAP_MONO   = 2'd2,
        MAP_COLOR  = 2'd3
    } map_mode_e;

    localparam int unsigned NUM_MODES = 4;

    // Lowest byte of the legacy graphics aperture.
    localparam logic [31:0] APERTURE_LO = 32'h000A_0000;
    // One past the highest byte of the aperture.
    localparam logic [31:0] APERTURE_HI = 32'h000C_0000;
    // Offset that places bank 0 at the aperture base (two's complement of the base).
    localparam logic [31:0] BANK0_OFFSET = 32'hFFF6_0000;

    // Inclusive lower bound of the window for a given mode.
    function automatic logic [31:0] win_lo(input int m);
        case (m)
            0, 1:    return 32'h000A_0000;
            2:       return 32'h000B_0000;
            default: return 32'h000B_8000;
        endcase
    endfunction

    // Exclusive upper bound of the window for a given mode.
    function automatic logic [31:0] win_hi(input int m);
        case (m)
            0:       return 32'h000C_0000;
            1:       return 32'h000B_0000;
            2:       return 32'h000B_8000;
            default: return 32'h000C_0000;
        endcase
    endfunction

endpackage

// File: rtl/wmap_bank_reg.sv
// Bank offset register for the relocatable 64 KiB window.
// Holds (masked_bank << 16) - aperture base, modulo 2^32.
// Assumes VRAM_AW > 16 and VRAM_AW - 16 <= BANK_W.
module wmap_bank_reg #(
    parameter int unsigned VRAM_AW = 22,
    parameter int unsigned BANK_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bank_we,
    input  logic [BANK_W-1:0] bank_num,
    input  logic              mode_we,
    input  logic              ext_enable,
    output logic [31:0]       bank_offset
);
    import wmap_pkg::*;

    localparam int unsigned       BANK_BITS = VRAM_AW - 16;
    localparam logic [BANK_W-1:0] BANK_MASK = BANK_W'((32'd1 << BANK_BITS) - 32'd1);

    logic [BANK_W-1:0] bank_masked;
    logic [31:0]       bank_base;
    logic              restore_bank0;

    // Clamp the bank number to the banks that exist in RAM.
    assign bank_masked = bank_num & BANK_MASK;
    // Byte address of the selected bank inside video RAM.
    assign bank_base = {{(32-BANK_W){1'b0}}, bank_masked} << 16;
    // A disabling write of the extended-mode enable puts bank 0 back.
    assign restore_bank0 = mode_we & ~ext_enable;

    // Offset register: bank 0 on reset or disable, otherwise loaded by bank writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_offset <= BANK0_OFFSET;
        end else if (restore_bank0) begin
            bank_offset <= BANK0_OFFSET;
        end else if (bank_we) begin
            bank_offset <= bank_base - APERTURE_LO;
        end
    end

    // R4: a disabling mode write leaves the window on bank 0.
    a_r4_disable_restores: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mode_we && !ext_enable) |-> (bank_offset == BANK0_OFFSET));

    // R3: a bank write lands the window on the masked bank.
    a_r3_bank_masked: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bank_we && !(mode_we && !ext_enable)) |->
        ((bank_offset + APERTURE_LO) ==
         ({{(32-BANK_W){1'b0}}, ($past(bank_num) & BANK_MASK)} << 16)));

    // R4: without a bank or disabling write the offset is held.
    a_r4_offset_held: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!bank_we) && $past(!(mode_we && !ext_enable))) |-> $stable(bank_offset));

endmodule

// File: rtl/wmap_xlate.sv
// Combinational window decode and address translation.
// One comparator pair and one adder per mode are built in parallel; map_mode
// selects the result. Assumes bank_offset comes from wmap_bank_reg.
module wmap_xlate #(
    parameter int unsigned HOST_AW = 32,
    parameter int unsigned VRAM_AW = 22
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [1:0]         map_mode,
    input  logic [31:0]        bank_offset,
    output logic               win_hit,
    output logic [VRAM_AW-1:0] ram_addr
);
    import wmap_pkg::*;

    logic [NUM_MODES-1:0] hit_m;
    logic [31:0]          sum_m [NUM_MODES];
    logic [31:0]          addr32;
    logic [31:0]          sel_sum;

    // Host address in the 32-bit offset domain.
    assign addr32 = 32'(host_addr);

    for (genvar g = 0; g < NUM_MODES; g++) begin : g_mode
        localparam logic [31:0]        LO   = win_lo(g);
        localparam logic [31:0]        HI   = win_hi(g);
        localparam logic [HOST_AW-1:0] LO_H = HOST_AW'(LO);
        localparam logic [HOST_AW-1:0] HI_H = HOST_AW'(HI);
        logic [31:0] off_g;

        if (g == 1) begin : g_banked
            // Relocatable window: offset comes from the bank register.
            assign off_g = bank_offset;
        end else begin : g_fixed
            // Fixed window: offset removes the window base.
            assign off_g = 32'd0 - LO;
        end

        // Window hit test on the full host address.
        assign hit_m[g] = (host_addr >= LO_H) && (host_addr < HI_H);
        // Translated address, modulo 2^32.
        assign sum_m[g] = addr32 + off_g;
    end

    // Pick the active mode's result.
    assign win_hit  = hit_m[map_mode];
    assign sel_sum  = sum_m[map_mode];
    assign ram_addr = sel_sum[VRAM_AW-1:0];

    // R2: the banked window stops below 0xB0000.
    a_r2_banked_limit: assert property (@(posedge clk) disable iff (!rst_n)
        ((map_mode == 2'd1) && (host_addr >= HOST_AW'(32'h000B_0000))) |-> !win_hit);

    // R7: nothing outside the legacy aperture is ever accepted.
    a_r7_inside_aperture: assert property (@(posedge clk) disable iff (!rst_n)
        win_hit |-> ((host_addr >= HOST_AW'(APERTURE_LO)) && (host_addr < HOST_AW'(APERTURE_HI))));

    // R2: the masked bank keeps accepted addresses inside RAM, so truncation loses nothing.
    a_r2_no_truncation_loss: assert property (@(posedge clk) disable iff (!rst_n)
        win_hit |-> (sel_sum[31:VRAM_AW] == '0));

endmodule

// File: rtl/wmap_req_stage.sv
// Request register stage: drives the RAM strobes one cycle after a host request
// and records whether a read is pending and whether it was rejected.
// Assumes host_rd and host_wr are never high together.
module wmap_req_stage #(
    parameter int unsigned VRAM_AW = 22
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_rd,
    input  logic               host_wr,
    input  logic [7:0]         host_wdata,
    input  logic               win_hit,
    input  logic [VRAM_AW-1:0] ram_addr,
    output logic [VRAM_AW-1:0] vram_addr,
    output logic               vram_en,
    output logic               vram_we,
    output logic [7:0]         vram_wdata,
    output logic               rd_pend,
    output logic               rd_rej
);
    logic accept;

    // A request proceeds to RAM only when it hits the window.
    assign accept = win_hit & (host_rd | host_wr);

    // RAM strobes: pulse for accepted requests only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vram_en <= 1'b0;
            vram_we <= 1'b0;
        end else begin
            vram_en <= accept;
            vram_we <= win_hit & host_wr;
        end
    end

    // RAM address and data: loaded only on accepted requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vram_addr  <= '0;
            vram_wdata <= '0;
        end else if (accept) begin
            vram_addr  <= ram_addr;
            vram_wdata <= host_wdata;
        end
    end

    // Read tracking: every read is answered, rejected ones flagged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend <= 1'b0;
            rd_rej  <= 1'b0;
        end else begin
            rd_pend <= host_rd;
            rd_rej  <= host_rd & ~win_hit;
        end
    end

    // R8: input rule, a single strobe per cycle.
    a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_rd && host_wr));

    // R7: the RAM is only enabled in answer to a host request.
    a_r7_en_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        vram_en |-> $past(host_rd || host_wr));

    // R10: a RAM write is always an enabled access.
    a_r10_we_within_en: assert property (@(posedge clk) disable iff (!rst_n)
        vram_we |-> vram_en);

    // R10: write data presented to RAM is the host byte of the request.
    a_r10_wdata_follows: assert property (@(posedge clk) disable iff (!rst_n)
        vram_we |-> (vram_wdata == $past(host_wdata)));

endmodule

// File: rtl/wmap_rsp.sv
// Read return stage: answers each read two cycles after the request.
// A rejected read gets 0xFF in place of RAM data. Assumes RAM data arrives
// one cycle after vram_en.
module wmap_rsp (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_pend,
    input  logic       rd_rej,
    input  logic [7:0] vram_rdata,
    output logic [7:0] host_rdata,
    output logic       host_rvalid
);
    localparam logic [7:0] MISS_BYTE = 8'hFF;

    logic rej_q;

    // Return-cycle flags, aligned with the RAM's read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rvalid <= 1'b0;
            rej_q       <= 1'b0;
        end else begin
            host_rvalid <= rd_pend;
            rej_q       <= rd_rej;
        end
    end

    // Read data mux: fixed byte for a miss, RAM byte for a hit, zero when idle.
    always_comb begin
        if (!host_rvalid) begin
            host_rdata = 8'h00;
        end else if (rej_q) begin
            host_rdata = MISS_BYTE;
        end else begin
            host_rdata = vram_rdata;
        end
    end

    // R8: a valid return always follows a pending read.
    a_r8_valid_after_pend: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |-> $past(rd_pend));

    // R7: a rejected read returns the fixed miss byte.
    a_r7_miss_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rvalid && $past(rd_rej)) |-> (host_rdata == MISS_BYTE));

endmodule

// File: rtl/wmap_top.sv
// Banked framebuffer window address mapper, top level.
// Decodes host accesses in the legacy aperture, relocates the 64 KiB banked
// window, gates misses and returns read data two cycles after a read.
module wmap_top #(
    parameter int unsigned HOST_AW = 32,
    parameter int unsigned VRAM_AW = 22,
    parameter int unsigned BANK_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic               host_rd,
    input  logic               host_wr,
    input  logic [7:0]         host_wdata,
    input  logic [1:0]         map_mode,
    input  logic               bank_we,
    input  logic [BANK_W-1:0]  bank_num,
    input  logic               mode_we,
    input  logic               ext_enable,
    output logic [VRAM_AW-1:0] vram_addr,
    output logic               vram_en,
    output logic               vram_we,
    output logic [7:0]         vram_wdata,
    input  logic [7:0]         vram_rdata,
    output logic [7:0]         host_rdata,
    output logic               host_rvalid
);
    logic [31:0]        bank_offset;
    logic               win_hit;
    logic [VRAM_AW-1:0] ram_addr;
    logic               rd_pend;
    logic               rd_rej;

    wmap_bank_reg #(.VRAM_AW(VRAM_AW), .BANK_W(BANK_W)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .bank_we     (bank_we),
        .bank_num    (bank_num),
        .mode_we     (mode_we),
        .ext_enable  (ext_enable),
        .bank_offset (bank_offset)
    );

    wmap_xlate #(.HOST_AW(HOST_AW), .VRAM_AW(VRAM_AW)) u_xlate (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_addr   (host_addr),
        .map_mode    (map_mode),
        .bank_offset (bank_offset),
        .win_hit     (win_hit),
        .ram_addr    (ram_addr)
    );

    wmap_req_stage #(.VRAM_AW(VRAM_AW)) u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_rd    (host_rd),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .win_hit    (win_hit),
        .ram_addr   (ram_addr),
        .vram_addr  (vram_addr),
        .vram_en    (vram_en),
        .vram_we    (vram_we),
        .vram_wdata (vram_wdata),
        .rd_pend    (rd_pend),
        .rd_rej     (rd_rej)
    );

    wmap_rsp u_rsp (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_pend     (rd_pend),
        .rd_rej      (rd_rej),
        .vram_rdata  (vram_rdata),
        .host_rdata  (host_rdata),
        .host_rvalid (host_rvalid)
    );

    // R8: every read request is answered exactly two cycles later.
    a_r8_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
        $past(host_rd, 2) |-> host_rvalid);

    // R8: a write request never produces a read return.
    a_r8_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
        $past(host_wr, 2) |-> !host_rvalid);

endmodule

// File: tb/wmap_top_tb.sv
module wmap_top_tb;
    localparam int unsigned VRAM_AW = 22;
    localparam int unsigned WATCHDOG = 20000;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [31:0]        host_addr = '0;
    logic               host_rd = 1'b0;
    logic               host_wr = 1'b0;
    logic [7:0]         host_wdata = '0;
    logic [1:0]         map_mode = '0;
    logic               bank_we = 1'b0;
    logic [15:0]        bank_num = '0;
    logic               mode_we = 1'b0;
    logic               ext_enable = 1'b0;
    logic [VRAM_AW-1:0] vram_addr;
    logic               vram_en;
    logic               vram_we;
    logic [7:0]         vram_wdata;
    logic [7:0]         vram_rdata = '0;
    logic [7:0]         host_rdata;
    logic               host_rvalid;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wmap_top u_dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
        .host_wr(host_wr), .host_wdata(host_wdata), .map_mode(map_mode),
        .bank_we(bank_we), .bank_num(bank_num), .mode_we(mode_we),
        .ext_enable(ext_enable), .vram_addr(vram_addr), .vram_en(vram_en),
        .vram_we(vram_we), .vram_wdata(vram_wdata), .vram_rdata(vram_rdata),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid)
    );

    // RAM model: byte derived from the address, returned one cycle after vram_en.
    function automatic logic [7:0] ram_byte(input logic [VRAM_AW-1:0] a);
        return 8'h5A ^ a[7:0] ^ a[15:8] ^ a[21:14];
    endfunction

    always @(posedge clk) begin
        if (vram_en && !vram_we) vram_rdata <= ram_byte(vram_addr);
    end

    typedef struct packed {
        logic [3:0]         req;
        logic [15:0]        bank;
        logic [1:0]         mode;
        logic [31:0]        addr;
        logic               wr;
        logic               hit;
        logic [VRAM_AW-1:0] vaddr;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{4'd1, 16'h0000, 2'd0, 32'h000A_0000, 1'b0, 1'b1, 22'h000000}, // R1 base
        '{4'd1, 16'h0000, 2'd0, 32'h000B_FFFF, 1'b0, 1'b1, 22'h01FFFF}, // R1 top
        '{4'd7, 16'h0000, 2'd0, 32'h000C_0000, 1'b0, 1'b0, 22'h000000}, // R7 above
        '{4'd7, 16'h0000, 2'd0, 32'h0009_FFFF, 1'b1, 1'b0, 22'h000000}, // R7 below
        '{4'd2, 16'h0000, 2'd1, 32'h000A_1234, 1'b0, 1'b1, 22'h001234}, // R2 bank 0
        '{4'd2, 16'h0005, 2'd1, 32'h000A_FFFF, 1'b0, 1'b1, 22'h05FFFF}, // R2 bank 5 top
        '{4'd2, 16'h0005, 2'd1, 32'h000B_0000, 1'b0, 1'b0, 22'h000000}, // R2 limit
        '{4'd3, 16'h0047, 2'd1, 32'h000A_0010, 1'b0, 1'b1, 22'h070010}, // R3 mask
        '{4'd10,16'h003F, 2'd1, 32'h000A_8000, 1'b1, 1'b1, 22'h3F8000}, // R10 write, R3 top bank
        '{4'd5, 16'h0000, 2'd2, 32'h000B_0000, 1'b0, 1'b1, 22'h000000}, // R5 base
        '{4'd5, 16'h0000, 2'd2, 32'h000B_7FFF, 1'b1, 1'b1, 22'h007FFF}, // R5 top write
        '{4'd5, 16'h0000, 2'd2, 32'h000B_8000, 1'b0, 1'b0, 22'h000000}, // R5 limit
        '{4'd6, 16'h0000, 2'd3, 32'h000B_8000, 1'b0, 1'b1, 22'h000000}, // R6 base
        '{4'd6, 16'h0000, 2'd3, 32'h000B_FFFF, 1'b0, 1'b1, 22'h007FFF}, // R6 top
        '{4'd6, 16'h0000, 2'd3, 32'h000C_0000, 1'b1, 1'b0, 22'h000000}, // R6 write above
        '{4'd6, 16'h0000, 2'd3, 32'h000B_7FFF, 1'b0, 1'b0, 22'h000000}, // R6 below
        '{4'd7, 16'h0000, 2'd0, 32'h100A_0000, 1'b0, 1'b0, 22'h000000}, // R7 wide address
        '{4'd1, 16'h0002, 2'd0, 32'h000A_0005, 1'b0, 1'b1, 22'h000005}, // R1 bank ignored
        '{4'd3, 16'h00C0, 2'd1, 32'h000A_0001, 1'b0, 1'b1, 22'h000001}  // R3 mask to 0
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic set_bank(input logic [15:0] b);
        @(negedge clk);
        bank_we = 1'b1; bank_num = b;
        @(negedge clk);
        bank_we = 1'b0;
    endtask

    task automatic write_mode(input logic en);
        @(negedge clk);
        mode_we = 1'b1; ext_enable = en;
        @(negedge clk);
        mode_we = 1'b0;
    endtask

    // One request; checks RAM strobes one cycle later and the return two cycles later.
    task automatic access(input string req, input logic [1:0] m, input logic [31:0] a,
                          input logic w, input logic h, input logic [VRAM_AW-1:0] va);
        logic [7:0] wd;
        wd = a[7:0] ^ 8'hC3;
        @(negedge clk);
        map_mode = m; host_addr = a; host_rd = !w; host_wr = w; host_wdata = wd;
        @(negedge clk);
        host_rd = 1'b0; host_wr = 1'b0;
        chk(req, "vram_en", 32'(vram_en), 32'(h));
        chk(req, "vram_we", 32'(vram_we), 32'(h & w));
        if (h) chk(req, "vram_addr", 32'(vram_addr), 32'(va));
        if (h && w) chk("R10", "vram_wdata", 32'(vram_wdata), 32'(wd));
        @(negedge clk);
        chk("R8", "host_rvalid", 32'(host_rvalid), 32'(!w));
        if (!w) chk(h ? "R9" : "R7", "host_rdata", 32'(host_rdata),
                    32'(h ? ram_byte(va) : 8'hFF));
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R8 watchdog expired: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R8 reset state
        chk("R8", "reset vram_en", 32'(vram_en), 32'd0);
        chk("R8", "reset vram_we", 32'(vram_we), 32'd0);
        chk("R8", "reset host_rvalid", 32'(host_rvalid), 32'd0);
        // R4: after reset the banked window sits on bank 0
        access("R4", 2'd1, 32'h000A_0042, 1'b0, 1'b1, 22'h000042);

        for (int i = 0; i < NV; i++) begin
            set_bank(VECS[i].bank);
            access($sformatf("R%0d", VECS[i].req), VECS[i].mode, VECS[i].addr,
                   VECS[i].wr, VECS[i].hit, VECS[i].vaddr);
        end

        // R4: reset mid-run restores bank 0
        set_bank(16'h0009);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        access("R4", 2'd1, 32'h000A_0100, 1'b0, 1'b1, 22'h000100);

        // R4: disabling mode write restores bank 0
        set_bank(16'h0009);
        write_mode(1'b0);
        access("R4", 2'd1, 32'h000A_0100, 1'b0, 1'b1, 22'h000100);

        // R4: enabling mode write keeps the bank
        set_bank(16'h0009);
        write_mode(1'b1);
        access("R4", 2'd1, 32'h000A_0100, 1'b0, 1'b1, 22'h090100);

        // R4: disable wins over a bank write in the same cycle
        @(negedge clk);
        bank_we = 1'b1; bank_num = 16'h000B; mode_we = 1'b1; ext_enable = 1'b0;
        @(negedge clk);
        bank_we = 1'b0; mode_we = 1'b0;
        access("R4", 2'd1, 32'h000A_0100, 1'b0, 1'b1, 22'h000100);

        // R8/R7: back-to-back reads, a rejected one followed by an accepted one
        @(negedge clk);
        map_mode = 2'd0; host_addr = 32'h000C_0004; host_rd = 1'b1;
        @(negedge clk);
        host_addr = 32'h000A_0003;
        chk("R7", "pipelined miss vram_en", 32'(vram_en), 32'd0);
        @(negedge clk);
        host_rd = 1'b0;
        chk("R8", "pipelined hit vram_addr", 32'(vram_addr), 32'h3);
        chk("R8", "first return valid", 32'(host_rvalid), 32'd1);
        chk("R7", "first return miss byte", 32'(host_rdata), 32'hFF);
        @(negedge clk);
        chk("R8", "second return valid", 32'(host_rvalid), 32'd1);
        chk("R9", "second return data", 32'(host_rdata), 32'(ram_byte(22'h3)));
        @(negedge clk);
        chk("R8", "idle after returns", 32'(host_rvalid), 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule